// File: doc/BRIEF.md
# Warp Branch Divergence and Reconvergence Mask Unit

This unit keeps the program counter and the active-lane mask of one 32-lane warp while the warp runs through conditional branches. All lanes share one instruction fetch, so one PC and one mask describe the whole warp. The mask goes straight out as a per-lane write enable, so a lane that is switched off keeps its state. The issue stage raises `step_i` for each instruction it sends. For a conditional branch it also gives the per-lane predicate, the branch target and the join address where both sides meet again.

Only the predicate bits of active lanes count. If those lanes all agree, the branch acts like a plain jump or a plain fall-through, and nothing is saved. If they disagree, the unit saves a record on a small LIFO and runs the taken side first under the taken subset. The record holds the join address, the fall-through address, the fall-through subset and the mask before the branch. When the PC reaches the saved join address, the unit uses one switch cycle to start the fall-through side under the other subset. On the next arrival at the join address it uses a second switch cycle to restore the pre-branch mask and drop the record. During each switch cycle `ready_o` is low. A chain of records that share one join address therefore unwinds one switch cycle at a time. Nested regions are supported up to the LIFO depth. A divergent branch that finds the LIFO full is not executed, and a sticky error flag is raised.

Top module: `simt_mask_unit`

## Requirements
- R1: After a synchronous active-low reset, `pc_o` is 0, `lane_we_o` is all ones (32'hFFFF_FFFF), `ready_o` is 1 and `overflow_o` is 0.
- R2: On a clock edge with `ready_o` high, `step_i` high and `br_i` low, `pc_o` becomes the old PC plus one and the mask does not change. With `step_i` low, PC and mask hold.
- R3: On an issued branch where every active lane has its predicate bit set, `pc_o` becomes `target_i`, the mask does not change and nothing is saved. A later arrival at that branch's `join_pc_i` does not drop `ready_o`.
- R4: On an issued branch where no active lane has its predicate bit set, `pc_o` becomes the old PC plus one and the mask does not change. Predicate bits of inactive lanes are ignored.
- R5: On an issued branch where the active lanes disagree, `pc_o` becomes `target_i` and the mask becomes predicate AND old mask, which is never zero and never larger than the old mask.
- R6: When `pc_o` equals the join address of the newest saved record, and that record's fall-through side has not yet run, `ready_o` is low. At the next edge `pc_o` becomes the branch PC plus one and the mask becomes NOT predicate AND pre-branch mask.
- R7: When `pc_o` equals that join address again, after the fall-through side, `ready_o` is low. At the next edge `pc_o` equals the join address, the mask is the pre-branch mask and the record is dropped. If the next older record has the same join address, it is handled the same way on the following cycles.
- R8: Up to 8 records can be held at once. A divergent branch issued while 8 are held leaves PC and mask unchanged and sets `overflow_o`, which stays set until reset.
- R9: While `ready_o` is low, `step_i` and the branch inputs have no effect and `overflow_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | One instruction issued this cycle |
| br_i | input | 1 | The issued instruction is a conditional branch |
| pred_i | input | 32 | Per-lane branch predicate, 1 = lane takes the branch |
| target_i | input | 16 | Branch target address |
| join_pc_i | input | 16 | Address where both sides of the branch meet again |
| ready_o | output | 1 | Low during a join switch cycle, when issue is ignored |
| pc_o | output | 16 | PC of the next instruction to issue |
| lane_we_o | output | 32 | Active-lane mask, used as the per-lane write enable |
| overflow_o | output | 1 | Sticky flag: a divergent branch found the LIFO full |

## Verification
Each issued step updates `pc_o` and `lane_we_o` on the same clock edge that samples it, so its result can be read one edge later. `ready_o` is combinational from that new state, so it drops in the same cycle the PC lands on a join address. Every join switch cycle therefore costs exactly one edge before the next issuable PC appears. The driver applies one set of inputs per cycle on the falling edge and queues the state expected after the following rising edge. The monitor compares that state 1 ns after the rising edge, so each switch cycle shows up as its own queued item with `ready_o` low.

// File: rtl/simt_pkg.sv
// Shared sizes and types for the warp divergence mask unit.
// Assumes one warp per unit and word-addressed instructions (next PC = PC + 1).
package simt_pkg;
    parameter int unsigned WARP_LANES  = 32;
    parameter int unsigned PC_BITS     = 16;
    parameter int unsigned JOIN_DEPTH  = 8;
    parameter logic [PC_BITS-1:0] BOOT_PC = '0;

    typedef logic [WARP_LANES-1:0] lane_mask_t;
    typedef logic [PC_BITS-1:0]    pc_t;

    // One saved divergence record.
    typedef struct packed {
        pc_t        join_pc;    // where the two sides meet
        pc_t        alt_pc;     // start of the fall-through side
        lane_mask_t alt_mask;   // lanes of the fall-through side
        lane_mask_t outer_mask; // mask before the branch
        logic       alt_done;   // fall-through side has been started
    } join_rec_t;
endpackage

// File: rtl/branch_split.sv
// Splits the active lanes of a warp by a branch predicate and classifies
// the branch as uniform-taken, uniform-not-taken or divergent.
// Assumes: purely combinational, predicate bits of inactive lanes are don't-care.
module branch_split
    import simt_pkg::*;
(
    input  lane_mask_t active_i,
    input  lane_mask_t pred_i,
    output lane_mask_t taken_o,
    output lane_mask_t fall_o,
    output logic       all_taken_o,
    output logic       diverge_o
);
    // Lane subsets and branch class.
    always_comb begin
        taken_o     = pred_i & active_i;
        fall_o      = ~pred_i & active_i;
        all_taken_o = (taken_o == active_i);
        diverge_o   = (taken_o != '0) && (fall_o != '0);
    end
endmodule

// File: rtl/join_stack.sv
// LIFO of divergence records with push, pop and mark-newest operations.
// Assumes: at most one operation per cycle (push has priority, then pop,
// then mark); a push while full or a pop or mark while empty is ignored.
// DEPTH must be a power of two.
module join_stack
    import simt_pkg::*;
#(
    parameter int unsigned DEPTH = JOIN_DEPTH
)(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  join_rec_t rec_i,
    input  logic      pop_i,
    input  logic      mark_i,
    output join_rec_t top_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0] fill_q;
    join_rec_t        slot_q [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;

    // Derived pointers and flags.
    always_comb begin
        wr_idx  = IDX_W'(fill_q);
        top_idx = IDX_W'(fill_q - CNT_W'(1));
        empty_o = (fill_q == '0);
        full_o  = (fill_q == CNT_W'(DEPTH));
        top_o   = slot_q[top_idx];
    end

    // Fill level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (push_i && !full_o)
            fill_q <= fill_q + CNT_W'(1);
        else if (pop_i && !empty_o)
            fill_q <= fill_q - CNT_W'(1);
    end

    // Record storage; no reset needed, reads are qualified by the fill level.
    always_ff @(posedge clk) begin
        if (push_i && !full_o)
            slot_q[wr_idx] <= rec_i;
        else if (!pop_i && mark_i && !empty_o)
            slot_q[top_idx].alt_done <= 1'b1;
    end
endmodule

// File: rtl/simt_mask_unit.sv
// Warp PC and active-lane mask sequencer with divergence handling.
// Uniform branches jump or fall through. Divergent branches save a record,
// run the taken lanes first, switch to the fall-through lanes at the join
// address, then restore the outer mask on the second arrival.
// Assumes: the issue stage honours ready_o; after a divergent branch, each
// side reaches the join address before any older join address.
module simt_mask_unit
    import simt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    input  logic                  br_i,
    input  logic [WARP_LANES-1:0] pred_i,
    input  logic [PC_BITS-1:0]    target_i,
    input  logic [PC_BITS-1:0]    join_pc_i,
    output logic                  ready_o,
    output logic [PC_BITS-1:0]    pc_o,
    output logic [WARP_LANES-1:0] lane_we_o,
    output logic                  overflow_o
);
    pc_t        pc_q, pc_d;
    lane_mask_t mask_q, mask_d;
    logic       ovf_q, ovf_set;

    lane_mask_t taken_m, fall_m;
    logic       all_taken, diverge;

    join_rec_t  new_rec, top_rec;
    logic       push, pop, mark, stk_empty, stk_full;
    logic       at_join, issue;
    pc_t        seq_pc;

    branch_split i_split (
        .active_i    (mask_q),
        .pred_i      (pred_i),
        .taken_o     (taken_m),
        .fall_o      (fall_m),
        .all_taken_o (all_taken),
        .diverge_o   (diverge)
    );

    join_stack #(.DEPTH(JOIN_DEPTH)) i_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .rec_i   (new_rec),
        .pop_i   (pop),
        .mark_i  (mark),
        .top_o   (top_rec),
        .empty_o (stk_empty),
        .full_o  (stk_full)
    );

    // Join detection and issue qualification.
    always_comb begin
        at_join = !stk_empty && (pc_q == top_rec.join_pc);
        issue   = step_i && !at_join;
        seq_pc  = pc_q + pc_t'(1);
        new_rec = '{join_pc:    join_pc_i,
                    alt_pc:     seq_pc,
                    alt_mask:   fall_m,
                    outer_mask: mask_q,
                    alt_done:   1'b0};
    end

    // Next PC, next mask and LIFO operation.
    always_comb begin
        pc_d    = pc_q;
        mask_d  = mask_q;
        push    = 1'b0;
        pop     = 1'b0;
        mark    = 1'b0;
        ovf_set = 1'b0;
        if (at_join) begin
            if (!top_rec.alt_done) begin
                pc_d   = top_rec.alt_pc;
                mask_d = top_rec.alt_mask;
                mark   = 1'b1;
            end else begin
                pc_d   = top_rec.join_pc;
                mask_d = top_rec.outer_mask;
                pop    = 1'b1;
            end
        end else if (issue) begin
            if (!br_i) begin
                pc_d = seq_pc;
            end else if (all_taken) begin
                pc_d = target_i;
            end else if (!diverge) begin
                pc_d = seq_pc;
            end else if (stk_full) begin
                ovf_set = 1'b1;
            end else begin
                push   = 1'b1;
                pc_d   = target_i;
                mask_d = taken_m;
            end
        end
    end

    // Warp state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= BOOT_PC;
            mask_q <= '1;
            ovf_q  <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
            ovf_q  <= ovf_q | ovf_set;
        end
    end

    // Outputs.
    always_comb begin
        ready_o    = !at_join;
        pc_o       = pc_q;
        lane_we_o  = mask_q;
        overflow_o = ovf_q;
    end
endmodule

// File: rtl/simt_mask_unit_chk.sv
// Port-level temporal checks for simt_mask_unit, attached by bind.
module simt_mask_unit_chk
    import simt_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  step_i,
    input logic                  br_i,
    input logic [WARP_LANES-1:0] pred_i,
    input logic                  ready_o,
    input logic [PC_BITS-1:0]    pc_o,
    input logic [WARP_LANES-1:0] lane_we_o,
    input logic                  overflow_o
);
    a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ready_o && !br_i) |=>
            (pc_o == pc_t'($past(pc_o) + 1'b1)) && $stable(lane_we_o));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && ready_o) |=> $stable(pc_o) && $stable(lane_we_o));

    a_r4_uniform_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ready_o && br_i && ((pred_i & lane_we_o) == '0)) |=>
            (pc_o == pc_t'($past(pc_o) + 1'b1)) && $stable(lane_we_o));

    a_r5_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ready_o && br_i) |=> ((lane_we_o & ~$past(lane_we_o)) == '0));

    a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we_o != '0);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    a_r8_hold_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> $stable(pc_o) && $stable(lane_we_o));

    a_r9_busy_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> $stable(overflow_o));
endmodule

bind simt_mask_unit simt_mask_unit_chk i_chk (.*);

// File: tb/test_simt_mask_unit.sv
// Scoreboard bench: the driver applies one cycle of stimulus on the falling
// edge and queues the expected state; the monitor compares 1 ns after the
// rising edge.
module test_simt_mask_unit;
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct {
        logic [15:0] pc;
        logic [31:0] mask;
        logic        rdy;
        logic        ovf;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic        br = 1'b0;
    logic [31:0] pred = '0;
    logic [15:0] tgt = '0;
    logic [15:0] jpc = '0;
    logic        ready;
    logic [15:0] pc;
    logic [31:0] we;
    logic        ovf;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    simt_mask_unit i_simt_mask_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .br_i       (br),
        .pred_i     (pred),
        .target_i   (tgt),
        .join_pc_i  (jpc),
        .ready_o    (ready),
        .pc_o       (pc),
        .lane_we_o  (we),
        .overflow_o (ovf)
    );

    // Driver: one cycle of stimulus plus the state expected after the edge.
    task automatic drive(input logic s, input logic b, input logic [31:0] p,
                         input logic [15:0] t, input logic [15:0] j,
                         input logic [15:0] e_pc, input logic [31:0] e_mask,
                         input logic e_rdy, input logic e_ovf, input string req);
        exp_t e;
        @(negedge clk);
        step = s; br = b; pred = p; tgt = t; jpc = j;
        e.pc = e_pc; e.mask = e_mask; e.rdy = e_rdy; e.ovf = e_ovf; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0; step = 1'b0; br = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        e.pc = 16'h0; e.mask = 32'hFFFF_FFFF; e.rdy = 1'b1; e.ovf = 1'b0; e.req = "R1";
        exp_q.push_back(e);
    endtask

    // Monitor: compare after each rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (pc !== e.pc || we !== e.mask || ready !== e.rdy || ovf !== e.ovf) begin
                n_fail++;
                $display("FAIL %s: pc=%h mask=%h rdy=%b ovf=%b expected pc=%h mask=%h rdy=%b ovf=%b",
                         e.req, pc, we, ready, ovf, e.pc, e.mask, e.rdy, e.ovf);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] m;
        logic [15:0] cur;
        do_reset();                                                     // R1
        drive(1, 0, 0, 0, 0, 16'h1, 32'hFFFF_FFFF, 1, 0, "R2");
        drive(0, 0, 0, 0, 0, 16'h1, 32'hFFFF_FFFF, 1, 0, "R2");
        drive(1, 1, 32'hFFFF_FFFF, 16'h10, 16'h20, 16'h10, 32'hFFFF_FFFF, 1, 0, "R3");
        drive(1, 1, 32'h0, 16'h77, 16'h78, 16'h11, 32'hFFFF_FFFF, 1, 0, "R4");
        drive(1, 1, 32'h0000_FFFF, 16'h30, 16'h40, 16'h30, 32'h0000_FFFF, 1, 0, "R5");
        drive(1, 0, 0, 0, 0, 16'h31, 32'h0000_FFFF, 1, 0, "R2");
        // inactive lanes' predicate bits ignored
        drive(1, 1, 32'hFFFF_0000, 16'h55, 16'h56, 16'h32, 32'h0000_FFFF, 1, 0, "R4");
        drive(1, 1, 32'hFFFF_FFFF, 16'h40, 16'h99, 16'h40, 32'h0000_FFFF, 0, 0, "R6");
        // switch cycle: step and branch inputs ignored
        drive(1, 1, 32'h0000_0001, 16'h66, 16'h67, 16'h12, 32'hFFFF_0000, 1, 0, "R9");
        drive(1, 0, 0, 0, 0, 16'h13, 32'hFFFF_0000, 1, 0, "R6");
        drive(1, 1, 32'hFFFF_FFFF, 16'h40, 16'h0, 16'h40, 32'hFFFF_0000, 0, 0, "R7");
        drive(0, 0, 0, 0, 0, 16'h40, 32'hFFFF_FFFF, 1, 0, "R7");
        // earlier uniform branch saved nothing: reaching its join keeps ready high
        drive(1, 1, 32'hFFFF_FFFF, 16'h20, 16'h0, 16'h20, 32'hFFFF_FFFF, 1, 0, "R3");
        drive(0, 0, 0, 0, 0, 16'h20, 32'hFFFF_FFFF, 1, 0, "R3");

        // fill the LIFO with 8 records, then overflow
        m = 32'hFFFF_FFFF;
        cur = 16'h20;
        for (int i = 0; i < 8; i++) begin
            m = m & ~(32'h1 << i);
            cur = 16'h100 + 16'(i * 16);
            drive(1, 1, ~(32'h1 << i), cur, 16'h200 + 16'(i), cur, m, 1, 0, "R8");
        end
        drive(1, 1, ~(32'h1 << 8), 16'h180, 16'h300, cur, m, 1, 1, "R8");
        drive(1, 0, 0, 0, 0, cur + 16'h1, m, 1, 1, "R8");

        // nested regions sharing one join address
        do_reset();
        drive(1, 1, 32'h0000_00FF, 16'h10, 16'h50, 16'h10, 32'h0000_00FF, 1, 0, "R5");
        drive(1, 1, 32'h0000_000F, 16'h20, 16'h50, 16'h20, 32'h0000_000F, 1, 0, "R5");
        drive(1, 1, 32'hFFFF_FFFF, 16'h50, 16'h0, 16'h50, 32'h0000_000F, 0, 0, "R6");
        drive(0, 0, 0, 0, 0, 16'h11, 32'h0000_00F0, 1, 0, "R6");
        drive(1, 1, 32'hFFFF_FFFF, 16'h50, 16'h0, 16'h50, 32'h0000_00F0, 0, 0, "R7");
        drive(0, 0, 0, 0, 0, 16'h50, 32'h0000_00FF, 0, 0, "R7");
        drive(0, 0, 0, 0, 0, 16'h01, 32'hFFFF_FF00, 1, 0, "R6");
        drive(1, 1, 32'hFFFF_FFFF, 16'h50, 16'h0, 16'h50, 32'hFFFF_FF00, 0, 0, "R7");
        drive(0, 0, 0, 0, 0, 16'h50, 32'hFFFF_FFFF, 1, 0, "R7");

        @(negedge clk);
        step = 1'b0; br = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule